// File: doc/BRIEF.md
# Service-Keyed Watchdog with Early Warning Interrupt

This block is a register-mapped watchdog timer with a halfword register port. It counts down in half-second units. An external one-cycle tick-enable pulse stands in for the clock divider. Software keeps the timer from expiring by writing a two-word key sequence to the service register. An interrupt can be raised a programmable number of ticks before expiry. When the count runs out, the block records the cause and can assert a timeout reset request that stays high until the chip reset.

Software can also request a reset by writing zero to the software-reset bit of the control register. Several configuration fields accept only their first write after reset. The enable bit and the timeout-request bit, once set, stay set until reset. The low-power wait, debug and suspend bits, the external-assertion bit and the power-down bit are stored and read back but have no other effect.

Register reads have one cycle of latency. The read data register captures the addressed register at each clock edge.

Top module: `wdg_top`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control), 0x2 (service), 0x4 (cause), 0x6 (early-warning control) and 0x8 (misc); address bit 0 is ignored. `rdata` shows the register addressed in the previous cycle. After reset the values are: control 0x0030, service 0x0000, cause 0x0000, early-warning 0x0004, misc 0x0001. After reset `irq`, `tout_rst` and `sw_rst` are 0.
- R2: Control bits 7 (wait disable), 1 (debug) and 0 (suspend) take the value of the first control write after reset. Later writes leave them unchanged.
- R3: Control bit 2 (enable) cannot be cleared by software once it is set. Writing it from 0 to 1 loads the counter with WT+1, where WT is control bits 15:8.
- R4: Control bit 3 (timeout request enable) cannot be cleared by software once it is set. `tout_rst` asserts only while this bit is set.
- R5: While enabled, each tick decrements the counter. The tick that brings it from 1 to 0 sets cause bit 1, and at that edge `tout_rst` rises if bit 3 is set. After WT+1 ticks without a service, `tout_rst` stays high until reset.
- R6: A service write of 0x5555 followed directly by a service write of 0xAAAA reloads the counter with WT+1 while enabled.
- R7: Any other order of service writes does not reload the counter. This includes 0xAAAA before 0x5555, or another service value between the two keys.
- R8: When a tick brings the counter to the early-warning value (bits 7:0 at 0x6) and bit 15 (interrupt enable) is set, bit 14 (status) sets and `irq` rises at that edge.
- R9: Writing 1 to early-warning bit 14 clears the status bit and `irq`.
- R10: Early-warning bits 15 and 7:0 take only the first write after reset. Later writes leave them unchanged.
- R11: A control write with bit 4 = 0 pulses `sw_rst` high for exactly one cycle and sets the cause register to 0x0001. Control bit 4 always reads 1.
- R12: While enable is 0, ticks have no effect: `tout_rst` stays 0 even with bit 3 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, one cycle after the address |
| tick | input | 1 | Half-second tick-enable pulse |
| irq | output | 1 | Early-warning interrupt |
| tout_rst | output | 1 | Timeout reset request, held until reset |
| sw_rst | output | 1 | One-cycle software reset pulse |

## Verification
The assertions assume that two control writes with bit 4 cleared are never issued in back-to-back cycles. Without that spacing, `sw_rst` would legitimately stay high for two cycles. The directed tasks issue at most one such write per scenario, and each is followed by a reset. All other checked properties follow from register state alone: the sticky enable, the sticky timeout request, the first-write locks and the interrupt gating hold for any sequence of writes and ticks. For that reason the stimulus mixes writes and ticks freely.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DW = 16;
  localparam int TW = 8;
  localparam int PW = 8;
  localparam int IW = 3;
  localparam logic [IW-1:0] IDX_CTRL = 3'd0;
  localparam logic [IW-1:0] IDX_SVC  = 3'd1;
  localparam logic [IW-1:0] IDX_CAUSE = 3'd2;
  localparam logic [IW-1:0] IDX_EW   = 3'd3;
  localparam logic [IW-1:0] IDX_MISC = 3'd4;
  localparam int C_SUSP = 0;
  localparam int C_DBG  = 1;
  localparam int C_EN   = 2;
  localparam int C_TRQ  = 3;
  localparam int C_SWR  = 4;
  localparam int C_EXT  = 5;
  localparam int C_WAIT = 7;
  localparam int EW_IE  = 15;
  localparam int EW_ST  = 14;
  localparam logic [DW-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [DW-1:0] KEY_SECOND = 16'hAAAA;
  localparam logic [PW-1:0] EW_DEFAULT = 8'h04;
endpackage

// File: rtl/wdg_svc_seq.sv
module wdg_svc_seq #(
  parameter int DW = 16,
  parameter logic [DW-1:0] K1 = 16'h5555,
  parameter logic [DW-1:0] K2 = 16'hAAAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] data,
  output logic          ok
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else if (wr) armed_q <= (data == K1);
  end

  assign ok = wr && armed_q && (data == K2);
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
  parameter int CW = 9,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  input  logic          tick,
  input  logic [PW-1:0] warn_val,
  output logic          expire,
  output logic          warn_hit
);
  logic [CW-1:0] cnt_q;
  logic          dec;
  logic [CW-1:0] cnt_nx;

  assign dec    = run && tick && !load && (cnt_q != '0);
  assign cnt_nx = cnt_q - CW'(1);
  assign expire   = dec && (cnt_q == CW'(1));
  assign warn_hit = dec && (cnt_nx == CW'(warn_val));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  input  logic          tick,
  output logic          irq,
  output logic          tout_rst,
  output logic          sw_rst
);
  localparam int CW = TW + 1;

  logic [TW-1:0] wt_q;
  logic          wait_q, ext_q, trq_q, en_q, dbg_q, susp_q, ctl_lk_q;
  logic [1:0]    cause_q;
  logic          ie_q, ist_q, ew_lk_q, pd_q;
  logic [PW-1:0] warn_q;
  logic [15:0]   rdata_q;
  logic          tout_q, swr_q;

  logic [AW-2:0] hidx;
  logic          wr_ctrl, wr_svc, wr_ew, wr_misc;
  logic          svc_ok, load, expire, warn_hit;
  logic [CW-1:0] load_val;
  logic [15:0]   ctrl_rd, ew_rd, rd_mux;

  assign hidx    = addr[AW-1:1];
  assign wr_ctrl = wr_en && (hidx == (AW-1)'(IDX_CTRL));
  assign wr_svc  = wr_en && (hidx == (AW-1)'(IDX_SVC));
  assign wr_ew   = wr_en && (hidx == (AW-1)'(IDX_EW));
  assign wr_misc = wr_en && (hidx == (AW-1)'(IDX_MISC));

  wdg_svc_seq #(.DW(DW), .K1(KEY_FIRST), .K2(KEY_SECOND)) u_seq (
    .clk(clk), .rst(rst), .wr(wr_svc), .data(wdata), .ok(svc_ok)
  );

  assign load     = (wr_ctrl && wdata[C_EN] && !en_q) || (svc_ok && en_q);
  assign load_val = wr_ctrl ? (CW'(wdata[15:8]) + CW'(1)) : (CW'(wt_q) + CW'(1));

  wdg_down_counter #(.CW(CW), .PW(PW)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .run(en_q),
    .tick(tick), .warn_val(warn_q), .expire(expire), .warn_hit(warn_hit)
  );

  // Control register: free fields, sticky bits and first-write locks
  always_ff @(posedge clk) begin
    if (rst) begin
      wt_q <= '0; ext_q <= 1'b1; trq_q <= 1'b0; en_q <= 1'b0;
      wait_q <= 1'b0; dbg_q <= 1'b0; susp_q <= 1'b0; ctl_lk_q <= 1'b0;
    end else if (wr_ctrl) begin
      wt_q  <= wdata[15:8];
      ext_q <= wdata[C_EXT];
      trq_q <= trq_q | wdata[C_TRQ];
      en_q  <= en_q | wdata[C_EN];
      if (!ctl_lk_q) begin
        wait_q <= wdata[C_WAIT];
        dbg_q  <= wdata[C_DBG];
        susp_q <= wdata[C_SUSP];
      end
      ctl_lk_q <= 1'b1;
    end
  end

  // Early-warning control, status and misc
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 1'b0; ist_q <= 1'b0; warn_q <= EW_DEFAULT; ew_lk_q <= 1'b0; pd_q <= 1'b1;
    end else begin
      if (wr_ew && !ew_lk_q) begin
        ie_q    <= wdata[EW_IE];
        warn_q  <= wdata[PW-1:0];
        ew_lk_q <= 1'b1;
      end
      if (warn_hit && ie_q)         ist_q <= 1'b1;
      else if (wr_ew && wdata[EW_ST]) ist_q <= 1'b0;
      if (wr_misc) pd_q <= wdata[0];
    end
  end

  // Reset requests and cause record
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= 2'b00; tout_q <= 1'b0; swr_q <= 1'b0;
    end else begin
      swr_q <= 1'b0;
      if (expire) begin
        cause_q <= 2'b10;
        if (trq_q) tout_q <= 1'b1;
      end
      if (wr_ctrl && !wdata[C_SWR]) begin
        swr_q   <= 1'b1;
        cause_q <= 2'b01;
      end
    end
  end

  assign ctrl_rd = {wt_q, wait_q, 1'b0, ext_q, 1'b1, trq_q, en_q, dbg_q, susp_q};
  assign ew_rd   = {ie_q, ist_q, {(14-PW){1'b0}}, warn_q};

  always_comb begin
    unique case (hidx)
      (AW-1)'(IDX_CTRL):  rd_mux = ctrl_rd;
      (AW-1)'(IDX_CAUSE): rd_mux = {14'd0, cause_q};
      (AW-1)'(IDX_EW):    rd_mux = ew_rd;
      (AW-1)'(IDX_MISC):  rd_mux = {15'd0, pd_q};
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata    = rdata_q;
  assign irq      = ist_q;
  assign tout_rst = tout_q;
  assign sw_rst   = swr_q;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
  input logic       clk,
  input logic       rst,
  input logic       sw_rst,
  input logic       tout_rst,
  input logic       irq,
  input logic       ie,
  input logic       trq,
  input logic       en,
  input logic       lk,
  input logic [2:0] lock_bits
);
  a_r11_swr_single: assert property (@(posedge clk) disable iff (rst) sw_rst |=> !sw_rst);
  a_r5_tout_holds: assert property (@(posedge clk) disable iff (rst) tout_rst |=> tout_rst);
  a_r4_tout_needs_trq: assert property (@(posedge clk) disable iff (rst) tout_rst |-> trq);
  a_r4_trq_sticky: assert property (@(posedge clk) disable iff (rst) trq |=> trq);
  a_r3_en_sticky: assert property (@(posedge clk) disable iff (rst) en |=> en);
  a_r2_locked_stable: assert property (@(posedge clk) disable iff (rst) lk |=> $stable(lock_bits));
  a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (rst) irq |-> ie);
endmodule

bind wdg_top wdg_chk u_chk (
  .clk(clk), .rst(rst), .sw_rst(sw_rst), .tout_rst(tout_rst), .irq(irq),
  .ie(ie_q), .trq(trq_q), .en(en_q), .lk(ctl_lk_q),
  .lock_bits({wait_q, dbg_q, susp_q})
);

// File: tb/wdg_top_tb.sv
module wdg_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tick = 1'b0;
  logic        irq, tout_rst, sw_rst;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdg_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .irq(irq), .tout_rst(tout_rst), .sw_rst(sw_rst)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; tick = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset_values();
    logic [15:0] d;
    do_reset();
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 tout_rst", {15'd0, tout_rst}, 16'd0);
    chk("R1 sw_rst", {15'd0, sw_rst}, 16'd0);
    rd(4'h0, d); chk("R1 ctrl", d, 16'h0030);
    rd(4'h2, d); chk("R1 svc", d, 16'h0000);
    rd(4'h4, d); chk("R1 cause", d, 16'h0000);
    rd(4'h7, d); chk("R1 ew (odd address)", d, 16'h0004);
    rd(4'h8, d); chk("R1 misc", d, 16'h0001);
  endtask

  task automatic t_ctrl_lock();
    logic [15:0] d;
    do_reset();
    wr(4'h0, 16'h0093);
    rd(4'h0, d); chk("R2 first write", d, 16'h0093);
    wr(4'h0, 16'h0010);
    rd(4'h0, d); chk("R2 locked bits kept", d, 16'h0093);
  endtask

  task automatic t_en_trq_sticky();
    logic [15:0] d;
    do_reset();
    wr(4'h0, 16'h021C);
    wr(4'h0, 16'h0210);
    rd(4'h0, d); chk("R3 R4 enable and request sticky", d, 16'h021C);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    do_reset();
    wr(4'h0, 16'h021C);
    ticks(2); chk("R5 not yet expired", {15'd0, tout_rst}, 16'd0);
    ticks(1); chk("R5 expired after WT+1", {15'd0, tout_rst}, 16'd1);
    rd(4'h4, d); chk("R5 cause timeout", d, 16'h0002);
    ticks(2); chk("R5 tout held", {15'd0, tout_rst}, 16'd1);
  endtask

  task automatic t_service_ok();
    do_reset();
    wr(4'h0, 16'h021C);
    ticks(2);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks(2); chk("R6 reloaded", {15'd0, tout_rst}, 16'd0);
    ticks(1); chk("R6 expires after reload", {15'd0, tout_rst}, 16'd1);
  endtask

  task automatic t_service_bad();
    do_reset();
    wr(4'h0, 16'h021C);
    ticks(2);
    wr(4'h2, 16'hAAAA); wr(4'h2, 16'h5555);
    ticks(1); chk("R7 reversed order no reload", {15'd0, tout_rst}, 16'd1);
    do_reset();
    wr(4'h0, 16'h021C);
    ticks(2);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    ticks(1); chk("R7 interrupted sequence no reload", {15'd0, tout_rst}, 16'd1);
  endtask

  task automatic t_early_warning();
    logic [15:0] d;
    do_reset();
    wr(4'h6, 16'h8004);
    wr(4'h0, 16'h071C);
    ticks(3); chk("R8 irq not early", {15'd0, irq}, 16'd0);
    ticks(1); chk("R8 irq at warning count", {15'd0, irq}, 16'd1);
    rd(4'h6, d); chk("R8 status bit", d, 16'hC004);
    wr(4'h6, 16'h4000);
    chk("R9 irq cleared", {15'd0, irq}, 16'd0);
    rd(4'h6, d); chk("R9 R10 status clear, fields locked", d, 16'h8004);
  endtask

  task automatic t_ew_lock();
    logic [15:0] d;
    do_reset();
    wr(4'h6, 16'h0002);
    rd(4'h6, d); chk("R10 first write", d, 16'h0002);
    wr(4'h6, 16'h80FF);
    rd(4'h6, d); chk("R10 later write ignored", d, 16'h0002);
    wr(4'h0, 16'h0314);
    ticks(3); chk("R10 irq disabled stays low", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_sw_reset();
    logic [15:0] d;
    do_reset();
    wr(4'h0, 16'h0000);
    chk("R11 pulse high", {15'd0, sw_rst}, 16'd1);
    @(negedge clk);
    chk("R11 pulse one cycle", {15'd0, sw_rst}, 16'd0);
    rd(4'h4, d); chk("R11 cause software", d, 16'h0001);
    rd(4'h0, d); chk("R11 bit4 reads 1", d, 16'h0010);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    do_reset();
    wr(4'h0, 16'h0018);
    ticks(4); chk("R12 no expiry while disabled", {15'd0, tout_rst}, 16'd0);
    rd(4'h4, d); chk("R12 cause untouched", d, 16'h0000);
    do_reset();
    wr(4'h0, 16'h0014);
    ticks(1); chk("R4 no request without bit3", {15'd0, tout_rst}, 16'd0);
    rd(4'h4, d); chk("R4 cause still recorded", d, 16'h0002);
  endtask

  initial begin
    t_reset_values();
    t_ctrl_lock();
    t_en_trq_sticky();
    t_timeout();
    t_service_ok();
    t_service_bad();
    t_early_warning();
    t_ew_lock();
    t_sw_reset();
    t_disabled();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule